// File: doc/BRIEF.md
# Cycle-by-cycle current limit controller

This block is the digital control core of a dual half-bridge driver. A host controller supplies a high-side and a low-side PWM command for each of two phases, synchronous to the block clock. The block turns these into four gate enables. It never lets both switches of one phase conduct together. Before any switch turns on, it waits a programmable number of idle cycles.

Two over-current flags arrive asynchronously from external comparators, one per phase. Each flag passes through a two-stage synchronizer. A synchronized flag sets a limit latch, which forces all four gates off and raises a status output. The latch records which phases tripped. It becomes ready to release once every flag is low and the high-side command of each recorded phase is low. It then releases on the next rising edge of either phase's high-side command. In most PWM schemes this resets the limit once per period.

A disable-all input forces every gate off at once and marks the outputs as high impedance. A limit-off input turns the current-limit function off entirely.

Top module: `cbc_limit_ctrl`

## Requirements
- R1: Bit p of `top_cmd`, `bot_cmd`, `oc_flag`, `gate_top` and `gate_bot` belongs to phase p. When only `top_cmd[p]` is high, `gate_top[p]` goes high. When only `bot_cmd[p]` is high, `gate_bot[p]` goes high. Either gate turns on once its dead time has elapsed.
- R2: `gate_top[p]` and `gate_bot[p]` are never high together. If both commands of a phase are high, both of its gates stay low.
- R3: A gate turns off at the first clock edge after its command drops. A gate of phase p turns on only after both gates of that phase have been low for at least `dead_cycles`+1 consecutive clock cycles. With `dead_cycles`=3, the opposite gate turns on at the fifth edge after the command swap.
- R4: A high `oc_flag` bit passes through two synchronizer flops and then sets the limit latch. When the flag rises between edges, `lim_stat` goes high at the third rising edge after the rise. From then on, all four gates are low in the same cycle.
- R5: `lim_stat` is high exactly while the latch is engaged. It is low in normal operation.
- R6: The latch records every phase whose flag trips. This includes both phases when both flags trip in the same cycle, and flags that trip while the latch is already engaged. The latch becomes eligible to clear only when all synchronized flags are low and the high-side commands of all recorded phases are low.
- R7: Once the latch is eligible, it clears at the first clock edge where either `top_cmd` bit is high after being low at the previous edge. A high-side command held constant never clears the latch, however long it is held.
- R8: While `dis_all` is high, all four gates are low and `out_hiz` is high, within the same cycle.
- R9: While `lim_off` is high, the flags are ignored and `lim_stat` is low. Asserting `lim_off` clears an engaged latch at the next edge.
- R10: During reset, all gates are low, `lim_stat` is low and no phase is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| top_cmd | input | 2 | High-side PWM command per phase |
| bot_cmd | input | 2 | Low-side PWM command per phase |
| oc_flag | input | 2 | Asynchronous over-current flag per phase |
| dis_all | input | 1 | Forces all gates off and outputs to high impedance |
| lim_off | input | 1 | Turns the current-limit function off |
| dead_cycles | input | DEAD_W | Dead time in clock cycles |
| gate_top | output | 2 | High-side gate enable per phase |
| gate_bot | output | 2 | Low-side gate enable per phase |
| out_hiz | output | 1 | Output stage marked high impedance |
| lim_stat | output | 1 | Current limit engaged |

## Verification
A table of static command pairs covers each phase's mapping and the both-high blocking case, and each row tells one gate assignment apart from its neighbours. Directed sequences cover the limit latch:
- a high-side command held at 100 % duty;
- a rising edge on the phase that did not trip, both while the latch is not yet eligible and after it is;
- a simultaneous two-phase trip;
- a flag held high while the tripped command is low.

These sequences show that the latch releases on the eligible edge and on no earlier one. A random command stream with sporadic trips then checks the dead-time gap, the absence of shoot-through and the absence of any output while the limit is engaged.

// File: rtl/cbc_limit_ctrl.sv
module cbc_limit_ctrl #(
  parameter int DEAD_W = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        top_cmd,
  input  logic [1:0]        bot_cmd,
  input  logic [1:0]        oc_flag,
  input  logic              dis_all,
  input  logic              lim_off,
  input  logic [DEAD_W-1:0] dead_cycles,
  output logic [1:0]        gate_top,
  output logic [1:0]        gate_bot,
  output logic              out_hiz,
  output logic              lim_stat
);
  localparam int NPH = 2;
  localparam int SW  = NPH * SYNC_N;

  logic [SW-1:0]     sync_sr;
  logic [NPH-1:0]    flag_s, top_q, trip_ph, rise, g_t, g_b, want_t, want_b;
  logic              lim, armed, blocked;
  logic [DEAD_W-1:0] off_cnt [NPH];

  assign flag_s  = sync_sr[SW-1 -: NPH];
  assign rise    = top_cmd & ~top_q;
  assign blocked = lim | dis_all;
  assign want_t  = top_cmd & ~bot_cmd & {NPH{~blocked}};
  assign want_b  = bot_cmd & ~top_cmd & {NPH{~blocked}};

  assign gate_top = g_t & {NPH{~blocked}};
  assign gate_bot = g_b & {NPH{~blocked}};
  assign out_hiz  = dis_all;
  assign lim_stat = lim;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_sr <= '0;
    else        sync_sr <= {sync_sr[SW-NPH-1:0], oc_flag};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim     <= 1'b0;
      armed   <= 1'b0;
      trip_ph <= '0;
      top_q   <= '0;
    end else begin
      top_q <= top_cmd;
      if (lim_off) begin
        lim     <= 1'b0;
        armed   <= 1'b0;
        trip_ph <= '0;
      end else if (|flag_s) begin
        lim     <= 1'b1;
        armed   <= 1'b0;
        trip_ph <= (lim ? trip_ph : '0) | flag_s;
      end else if (lim) begin
        if (!armed) begin
          armed <= ((top_cmd & trip_ph) == '0);
        end else if (|rise) begin
          lim     <= 1'b0;
          armed   <= 1'b0;
          trip_ph <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g_t <= '0;
      g_b <= '0;
      for (int p = 0; p < NPH; p++) off_cnt[p] <= '0;
    end else begin
      for (int p = 0; p < NPH; p++) begin
        if (g_t[p] | g_b[p])      off_cnt[p] <= '0;
        else if (off_cnt[p] != '1) off_cnt[p] <= off_cnt[p] + 1'b1;
        g_t[p] <= want_t[p] & (g_t[p] | (!g_b[p] && off_cnt[p] >= dead_cycles));
        g_b[p] <= want_b[p] & (g_b[p] | (!g_t[p] && off_cnt[p] >= dead_cycles));
      end
    end
  end

  // R2
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_top & gate_bot) == '0);

  for (genvar p = 0; p < NPH; p++) begin : g_dead_chk
    // R3
    dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(g_t[p]) || $rose(g_b[p])) |-> ($past(off_cnt[p]) >= $past(dead_cycles)));
  end

  // R4
  trip_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|flag_s) && !lim_off) |=> lim_stat);

  // R7
  clear_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lim_stat) |-> ($past(lim_off) || (|($past(top_cmd) & ~$past(top_cmd, 2)))));

  // R9
  lim_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lim_off |=> !lim_stat);
endmodule

// File: tb/sim_cbc_limit_ctrl.sv
`timescale 1ns/1ps
module sim_cbc_limit_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] top_cmd = '0, bot_cmd = '0, oc_flag = '0;
  logic dis_all = 1'b0, lim_off = 1'b0;
  logic [3:0] dead_cycles = 4'd3;
  logic [1:0] gate_top, gate_bot;
  logic out_hiz, lim_stat;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cbc_limit_ctrl #(.DEAD_W(4), .SYNC_N(2)) u0 (
    .clk(clk), .rst_n(rst_n), .top_cmd(top_cmd), .bot_cmd(bot_cmd),
    .oc_flag(oc_flag), .dis_all(dis_all), .lim_off(lim_off),
    .dead_cycles(dead_cycles), .gate_top(gate_top), .gate_bot(gate_bot),
    .out_hiz(out_hiz), .lim_stat(lim_stat));

  // {top_cmd, bot_cmd, expected gate_top, expected gate_bot}
  localparam logic [7:0] VEC [8] = '{
    8'b00_00_00_00, 8'b01_00_01_00, 8'b00_01_00_01, 8'b10_01_10_01,
    8'b11_00_11_00, 8'b00_11_00_11, 8'b01_01_00_00, 8'b11_10_01_00};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  // Monitors: dead-time gap (R3), no shoot-through (R2), no output while limited (R4)
  int lowcnt [2] = '{0, 0};
  bit seen [2] = '{1'b0, 1'b0};
  logic [1:0] prev [2] = '{2'b00, 2'b00};
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int p = 0; p < 2; p++) begin
        logic [1:0] g;
        g = {gate_top[p], gate_bot[p]};
        if (g != 2'b00 && prev[p] == 2'b00 && seen[p])
          chk("R3 dead gap", 8'(lowcnt[p] >= int'(dead_cycles) + 1), 8'd1);
        if (g == 2'b11) chk("R2 shoot-through", {6'd0, g}, 8'd0);
        if (g == 2'b00) lowcnt[p]++;
        else begin lowcnt[p] = 0; seen[p] = 1'b1; end
        prev[p] = g;
      end
      if (lim_stat) chk("R4 gates off while limited", {4'd0, gate_top, gate_bot}, 8'd0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end

  initial begin
    tick(3);
    chk("R10 reset gates", {4'd0, gate_top, gate_bot}, 8'd0);
    chk("R10 reset status", {7'd0, lim_stat}, 8'd0);
    rst_n = 1'b1;
    tick(2);

    for (int i = 0; i < 8; i++) begin
      {top_cmd, bot_cmd} = VEC[i][7:4];
      tick(8);
      chk($sformatf("R1 R2 vector %0d", i), {4'd0, gate_top, gate_bot}, {4'd0, VEC[i][3:0]});
    end

    // R3 exact dead-time switch-over on phase 0
    top_cmd = 2'b01; bot_cmd = 2'b00; tick(8);
    top_cmd = 2'b00; bot_cmd = 2'b01;
    tick(1);
    chk("R3 turn-off next edge", {7'd0, gate_top[0]}, 8'd0);
    tick(3);
    chk("R3 still in dead time", {7'd0, gate_bot[0]}, 8'd0);
    tick(1);
    chk("R3 on after dead time", {7'd0, gate_bot[0]}, 8'd1);

    // R4 R5 trip with phase 0 top held at 100 % duty
    bot_cmd = 2'b00; top_cmd = 2'b01; tick(8);
    oc_flag = 2'b01;
    tick(2);
    chk("R4 not yet latched", {7'd0, lim_stat}, 8'd0);
    tick(1);
    chk("R5 latched", {7'd0, lim_stat}, 8'd1);
    chk("R4 all gates off", {4'd0, gate_top, gate_bot}, 8'd0);
    oc_flag = 2'b00;
    tick(40);
    chk("R7 constant command keeps latch", {7'd0, lim_stat}, 8'd1);
    top_cmd = 2'b11; tick(3);
    chk("R6 other-phase edge before eligible", {7'd0, lim_stat}, 8'd1);
    top_cmd = 2'b00; tick(6);
    chk("R7 eligible but no edge", {7'd0, lim_stat}, 8'd1);
    top_cmd = 2'b10;
    #1 chk("R7 before release edge", {7'd0, lim_stat}, 8'd1);
    tick(1);
    chk("R7 released at edge", {7'd0, lim_stat}, 8'd0);
    tick(1);
    chk("R1 resumes after release", {6'd0, gate_top}, 8'h02);
    top_cmd = 2'b00; tick(6);

    // R6 simultaneous trip of both phases
    top_cmd = 2'b10;
    oc_flag = 2'b11; tick(3);
    chk("R6 dual trip latched", {7'd0, lim_stat}, 8'd1);
    oc_flag = 2'b00; tick(6);
    top_cmd = 2'b11; tick(1); top_cmd = 2'b10; tick(1);
    chk("R6 phase 1 recorded, top1 still high", {7'd0, lim_stat}, 8'd1);
    top_cmd = 2'b00; tick(6);
    top_cmd = 2'b01; tick(1);
    chk("R6 R7 dual trip released", {7'd0, lim_stat}, 8'd0);
    top_cmd = 2'b00; tick(6);

    // R6 flag held high blocks eligibility
    oc_flag = 2'b01; tick(4);
    chk("R5 latched again", {7'd0, lim_stat}, 8'd1);
    tick(4);
    top_cmd = 2'b10; tick(1);
    chk("R6 flag high blocks release", {7'd0, lim_stat}, 8'd1);
    oc_flag = 2'b00; tick(6);
    top_cmd = 2'b00; tick(1);
    top_cmd = 2'b10; tick(1);
    chk("R7 release after flag drops", {7'd0, lim_stat}, 8'd0);
    top_cmd = 2'b00; tick(6);

    // R8 disable-all
    top_cmd = 2'b01; tick(8);
    dis_all = 1'b1;
    #1 chk("R8 gates off same cycle", {4'd0, gate_top, gate_bot}, 8'd0);
    chk("R8 hiz flag", {7'd0, out_hiz}, 8'd1);
    tick(3);
    dis_all = 1'b0; tick(8);
    chk("R8 restored", {6'd0, gate_top}, 8'h01);
    chk("R8 hiz cleared", {7'd0, out_hiz}, 8'd0);

    // R9 limit-off mode
    oc_flag = 2'b01; tick(3);
    chk("R9 latched before mode", {7'd0, lim_stat}, 8'd1);
    lim_off = 1'b1; tick(1);
    chk("R9 mode clears latch", {7'd0, lim_stat}, 8'd0);
    oc_flag = 2'b11; tick(8);
    chk("R9 flags ignored", {7'd0, lim_stat}, 8'd0);
    chk("R9 gate follows command", {6'd0, gate_top}, 8'h01);
    oc_flag = 2'b00; lim_off = 1'b0; top_cmd = 2'b00; tick(6);

    // Random commands with sporadic trips; monitors check R2 R3 R4
    for (int c = 0; c < 3000; c++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'd0) begin top_cmd = r[5:4]; bot_cmd = r[7:6]; end
      if (r[15:10] == 6'd0) oc_flag = r[17:16];
      else if (r[13:11] == 3'd7) oc_flag = 2'b00;
      tick(1);
    end
    oc_flag = 2'b00; top_cmd = 2'b00; bot_cmd = 2'b00;
    tick(10);
    done = 1'b1;
    report();
  end
endmodule